// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Extended Lines

This block collects interrupt lines for a small group of processors and turns them into one prioritised request per processor. Fifteen primary lines, numbered 1 to 15, are latched as pending on a rising edge. Sixteen extended lines, numbered 16 to 31, can be added at build time. Every pending extended line is reported through one primary line, chosen by a parameter. Each processor has its own enable mask. For that processor the block drives a 4-bit request with the highest pending, enabled primary level, and it accepts an acknowledge that names a level.

When a processor acknowledges the shared primary line, the block chooses the lowest-numbered extended line that is pending and enabled for that processor. It clears that line and stores its number in the processor's identification register, so the handler knows which extended source it is serving. Software reaches the pending, clear, mask, status, identification and controller-select registers over a simple single-cycle register bus. The controller-select register holds one 4-bit field per processor, and the block drives each field out as a routing selector.

Top module: `mp_irq_ctrl`

## Requirements
- R1: A pending bit is set on a rising edge of its input line, never by a line that stays high, and bit 0 (number 0) never becomes pending.
- R2: With `EXT_LINE` = 0 the extension is absent, and pending bits 31:16 stay 0 whatever the inputs do.
- R3: The status register (word address 0x02) reads `EXT_LINE` in bits 19:16, `NCPU`-1 in bits 31:28 and 0 elsewhere.
- R4: Each processor has a mask register at word address 0x10+c. A bit at 1 enables that number for that processor. Bit 0 always reads 0, and so do bits 31:16 when the extension is absent.
- R5: `cpu_req` field c (bits 4c+3:4c) carries the highest-numbered primary level that is pending and enabled for processor c. It is 0 when there is none.
- R6: Any extended line that is pending and enabled for processor c makes level `EXT_LINE` count as pending for that processor. That level must itself also be enabled in the mask.
- R7: An acknowledge from processor c with a nonzero level clears that level's pending bit on the clock edge. An acknowledge with level 0 has no effect.
- R8: An acknowledge of level `EXT_LINE` also clears the lowest-numbered extended line that is pending and enabled for that processor. The processor's identification register (word address 0x18+c) then holds {1, offset}, where offset is the line number minus 16. If no such line exists, the register is loaded with 0.
- R9: A write to the clear register (word address 0x01) removes the pending state of every number whose bit is 1 in the written word. Reading that address returns 0.
- R10: A rising edge in the same cycle as an acknowledge or clear of that bit leaves the bit pending.
- R11: The controller-select register (word address 0x03) is read/write. Processor c's field sits at bits 31-4c:28-4c (processor 0 in the top nibble) and drives `cpu_csel` bits 4c+3:4c.
- R12: Writes to the pending register (word address 0x00) and to the identification registers are ignored.
- R13: After reset, pending, masks, identification, controller-select and all requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Interrupt inputs, bit n is number n (synchronous to clk) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| cpu_ack | input | NCPU | Acknowledge strobe per processor |
| cpu_ack_lvl | input | 4*NCPU | Level acknowledged, field c at 4c+3:4c |
| cpu_req | output | 4*NCPU | Request level per processor, 0 = none |
| cpu_csel | output | 4*NCPU | Controller-select field per processor |

## Verification
The contested cycle is one in which a pending bit is cleared and set again at once. This happens when a fresh rising edge on a line lands on the same clock as that processor's acknowledge of the line, or on the same clock as a clear-register write naming it. The bench drives both the edge and the acknowledge (or the write) at one falling edge and holds them across a single rising edge. It then requires the bit to read back as pending and the request to still name that level. A second pairing is the shared line: repeated acknowledges must hand out the extended lines one at a time from the lowest enabled upward, and they must skip lines that are masked for that processor.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int NLINES = 32;
  localparam int NPRIM  = 16;

  // Lines that may ever become pending for a given extension setting.
  function automatic logic [31:0] line_mask(input int ext_line);
    logic [31:0] m;
    m = 32'h0000_FFFE;
    if (ext_line != 0) m = m | 32'hFFFF_0000;
    return m;
  endfunction

  // Highest set bit among 15..1, 0 when none.
  function automatic logic [3:0] prio_high(input logic [15:0] v);
    logic [3:0] r;
    r = '0;
    for (int i = 1; i < 16; i++)
      if (v[i]) r = 4'(i);
    return r;
  endfunction

  // Lowest set bit of an extended vector as {found, offset}.
  function automatic logic [4:0] pick_low(input logic [15:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 15; i >= 0; i--)
      if (v[i]) r = {1'b1, 4'(i)};
    return r;
  endfunction

  // Controller-select nibble of processor c, processor 0 at the top.
  function automatic logic [3:0] sel_nibble(input logic [31:0] w, input int c);
    return 4'(w >> (28 - 4 * c));
  endfunction

endpackage

// File: rtl/irqc_pend.sv
module irqc_pend
  import irqc_pkg::*;
#(
  parameter int EXT_LINE = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] line_i,
  input  logic [31:0] clr_i,
  output logic [31:0] pend_o,
  output logic [31:0] rise_o
);

  localparam logic [31:0] VALID = line_mask(EXT_LINE);

  logic [31:0] line_q;
  logic [31:0] pend_q;

  assign rise_o = line_i & ~line_q & VALID;
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= line_i;
      pend_q <= (pend_q & ~clr_i) | rise_o;
    end
  end

endmodule

// File: rtl/irqc_cpu.sv
module irqc_cpu
  import irqc_pkg::*;
#(
  parameter int EXT_LINE = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pend_i,
  input  logic        mask_we,
  input  logic [31:0] wdata,
  input  logic        ack_i,
  input  logic [3:0]  ack_lvl_i,
  output logic [31:0] mask_o,
  output logic [4:0]  id_o,
  output logic [3:0]  req_o,
  output logic [31:0] clr_o,
  output logic [4:0]  ext_pick_o
);

  localparam logic [31:0] VALID = line_mask(EXT_LINE);

  logic [31:0] mask_q;
  logic [4:0]  id_q;
  logic [4:0]  ext_pick;
  logic [15:0] shared_vec;
  logic [15:0] eff_vec;
  logic        ack_hit;
  logic        ack_shared;

  generate
    if (EXT_LINE != 0) begin : g_ext
      assign ext_pick   = pick_low(pend_i[31:16] & mask_q[31:16]);
      assign shared_vec = 16'(ext_pick[4]) << EXT_LINE;
      assign ack_shared = ack_i && (ack_lvl_i == 4'(EXT_LINE));
    end else begin : g_noext
      assign ext_pick   = '0;
      assign shared_vec = '0;
      assign ack_shared = 1'b0;
    end
  endgenerate

  assign eff_vec    = (pend_i[15:0] | shared_vec) & mask_q[15:0];
  assign req_o      = prio_high(eff_vec);
  assign ack_hit    = ack_i && (ack_lvl_i != 4'd0);
  assign mask_o     = mask_q;
  assign id_o       = id_q;
  assign ext_pick_o = ext_pick;

  always_comb begin
    clr_o = '0;
    if (ack_hit) clr_o[ack_lvl_i] = 1'b1;
    if (ack_shared && ext_pick[4]) clr_o[5'd16 + {1'b0, ext_pick[3:0]}] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      id_q   <= '0;
    end else begin
      if (mask_we) mask_q <= wdata & VALID;
      if (ack_shared) id_q <= ext_pick;
    end
  end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter int EXT_LINE = 12,
  parameter int ADDR_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  input  logic [31:0]          pend_i,
  input  logic [NCPU*32-1:0]   mask_flat,
  input  logic [NCPU*5-1:0]    id_flat,
  output logic [31:0]          rdata_o,
  output logic [31:0]          clr_o,
  output logic [NCPU-1:0]      mask_we_o,
  output logic [31:0]          csel_o
);

  localparam logic [31:0] VALID  = line_mask(EXT_LINE);
  localparam int          A_PEND = 'h00;
  localparam int          A_CLR  = 'h01;
  localparam int          A_STAT = 'h02;
  localparam int          A_CSEL = 'h03;
  localparam int          A_MASK = 'h10;
  localparam int          A_ID   = 'h18;
  localparam logic [31:0] STATUS = {4'(NCPU - 1), 8'h00, 4'(EXT_LINE), 16'h0000};

  logic        wr_go;
  logic [31:0] csel_q;

  assign wr_go  = sel && wr;
  assign clr_o  = (wr_go && addr == ADDR_W'(A_CLR)) ? (wdata & VALID) : '0;
  assign csel_o = csel_q;

  for (genvar c = 0; c < NCPU; c++) begin : g_mwe
    assign mask_we_o[c] = wr_go && (addr == ADDR_W'(A_MASK + c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csel_q <= '0;
    else if (wr_go && addr == ADDR_W'(A_CSEL)) csel_q <= wdata;
  end

  always_comb begin
    rdata_o = '0;
    if (addr == ADDR_W'(A_PEND)) rdata_o = pend_i;
    if (addr == ADDR_W'(A_STAT)) rdata_o = STATUS;
    if (addr == ADDR_W'(A_CSEL)) rdata_o = csel_q;
    for (int c = 0; c < NCPU; c++) begin
      if (addr == ADDR_W'(A_MASK + c)) rdata_o = mask_flat[32*c +: 32];
      if (addr == ADDR_W'(A_ID + c))   rdata_o = {27'b0, id_flat[5*c +: 5]};
    end
  end

endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter int EXT_LINE = 12,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         irq_lines,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NCPU-1:0]     cpu_ack,
  input  logic [NCPU*4-1:0]   cpu_ack_lvl,
  output logic [NCPU*4-1:0]   cpu_req,
  output logic [NCPU*4-1:0]   cpu_csel
);

  logic [31:0]        pend_q;
  logic [31:0]        rise_w;
  logic [31:0]        bus_clr_w;
  logic [31:0]        clr_all_w;
  logic [NCPU-1:0]    mask_we_w;
  logic [NCPU*32-1:0] mask_flat_w;
  logic [NCPU*5-1:0]  id_flat_w;
  logic [NCPU*5-1:0]  pick_flat_w;
  logic [31:0]        csel_w;
  logic [31:0]        cpu_clr_w [NCPU];

  irqc_pend #(.EXT_LINE(EXT_LINE)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (irq_lines),
    .clr_i  (clr_all_w),
    .pend_o (pend_q),
    .rise_o (rise_w)
  );

  irqc_regs #(.NCPU(NCPU), .EXT_LINE(EXT_LINE), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (bus_sel),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .pend_i    (pend_q),
    .mask_flat (mask_flat_w),
    .id_flat   (id_flat_w),
    .rdata_o   (bus_rdata),
    .clr_o     (bus_clr_w),
    .mask_we_o (mask_we_w),
    .csel_o    (csel_w)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irqc_cpu #(.EXT_LINE(EXT_LINE)) u_cpu (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_i     (pend_q),
      .mask_we    (mask_we_w[c]),
      .wdata      (bus_wdata),
      .ack_i      (cpu_ack[c]),
      .ack_lvl_i  (cpu_ack_lvl[4*c +: 4]),
      .mask_o     (mask_flat_w[32*c +: 32]),
      .id_o       (id_flat_w[5*c +: 5]),
      .req_o      (cpu_req[4*c +: 4]),
      .clr_o      (cpu_clr_w[c]),
      .ext_pick_o (pick_flat_w[5*c +: 5])
    );
    assign cpu_csel[4*c +: 4] = sel_nibble(csel_w, c);
  end

  always_comb begin
    clr_all_w = bus_clr_w;
    for (int c = 0; c < NCPU; c++) clr_all_w = clr_all_w | cpu_clr_w[c];
  end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NCPU     = 2,
  parameter int EXT_LINE = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        pend,
  input logic [31:0]        rise,
  input logic [31:0]        clr,
  input logic [NCPU*4-1:0]  req,
  input logic [NCPU*32-1:0] mask_flat,
  input logic [NCPU*5-1:0]  id_flat,
  input logic [NCPU*5-1:0]  pick_flat
);

  a_r1_no_number0: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] == 1'b0);

  a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != 32'h0) |=> ((pend & $past(rise)) == $past(rise)));

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~rise) != 32'h0) |=> ((pend & $past(clr & ~rise)) == 32'h0));

  generate
    if (EXT_LINE == 0) begin : g_noext
      a_r2_ext_absent: assert property (@(posedge clk) disable iff (!rst_n)
        pend[31:16] == 16'h0);
    end
  endgenerate

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    logic [3:0]  req_c;
    logic [31:0] mask_c;
    logic [4:0]  id_c;
    logic [4:0]  pick_c;
    assign req_c  = req[4*c +: 4];
    assign mask_c = mask_flat[32*c +: 32];
    assign id_c   = id_flat[5*c +: 5];
    assign pick_c = pick_flat[5*c +: 5];

    a_r4_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (req_c != 4'd0) |-> mask_c[req_c]);

    a_r5_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (req_c != 4'd0) |-> (pend[req_c] ||
        ((req_c == 4'(EXT_LINE)) && ((pend[31:16] & mask_c[31:16]) != 16'h0))));

    a_r8_id_form: assert property (@(posedge clk) disable iff (!rst_n)
      !id_c[4] |-> (id_c[3:0] == 4'd0));

    a_r8_pick_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      pick_c[4] |-> (pend[5'd16 + {1'b0, pick_c[3:0]}] && mask_c[5'd16 + {1'b0, pick_c[3:0]}]));
  end

endmodule

bind mp_irq_ctrl irqc_chk #(.NCPU(NCPU), .EXT_LINE(EXT_LINE)) u_irqc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend      (pend_q),
  .rise      (rise_w),
  .clr       (clr_all_w),
  .req       (cpu_req),
  .mask_flat (mask_flat_w),
  .id_flat   (id_flat_w),
  .pick_flat (pick_flat_w)
);

// File: tb/test_mp_irq_ctrl.sv
`timescale 1ns/1ps
module test_mp_irq_ctrl;

  localparam int NCPU = 2;
  localparam int EXT  = 12;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     irq_lines = '0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCPU-1:0] cpu_ack = '0;
  logic [7:0]      cpu_ack_lvl = '0;
  logic [7:0]      cpu_req, cpu_csel;

  logic            p_sel = 1'b0;
  logic [AW-1:0]   p_addr = '0;
  logic [31:0]     p_rdata;
  logic [7:0]      p_req, p_csel;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  always #2.5 clk = ~clk;

  mp_irq_ctrl #(.NCPU(NCPU), .EXT_LINE(EXT), .ADDR_W(AW)) i_mp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_ack(cpu_ack), .cpu_ack_lvl(cpu_ack_lvl),
    .cpu_req(cpu_req), .cpu_csel(cpu_csel)
  );

  mp_irq_ctrl #(.NCPU(NCPU), .EXT_LINE(0), .ADDR_W(AW)) i_mp_irq_ctrl_plain (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_sel(p_sel), .bus_wr(1'b0), .bus_addr(p_addr),
    .bus_wdata(32'h0), .bus_rdata(p_rdata),
    .cpu_ack(2'b00), .cpu_ack_lvl(8'h00),
    .cpu_req(p_req), .cpu_csel(p_csel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] lines);
    @(negedge clk); irq_lines = irq_lines | lines;
    @(negedge clk); irq_lines = irq_lines & ~lines;
  endtask

  task automatic ack(input int c, input logic [3:0] lvl);
    @(negedge clk);
    cpu_ack[c] = 1'b1; cpu_ack_lvl[4*c +: 4] = lvl;
    @(negedge clk);
    cpu_ack = '0; cpu_ack_lvl = '0;
  endtask

  task automatic cleanup();
    wr('h01, 32'hFFFF_FFFF);
    wr('h10, 32'h0);
    wr('h11, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd('h00, d); chk("R13 pending after reset", d, 32'h0);
    rd('h10, d); chk("R13 mask0 after reset", d, 32'h0);
    rd('h18, d); chk("R13 id0 after reset", d, 32'h0);
    rd('h03, d); chk("R13 csel after reset", d, 32'h0);
    chk("R13 requests after reset", {24'h0, cpu_req}, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    rd('h02, d); chk("R3 status with extension", d, 32'h100C_0000);
    p_sel = 1'b1; p_addr = AW'('h02);
    #1 chk("R3 status without extension", p_rdata, 32'h1000_0000);
    p_sel = 1'b0;
  endtask

  task automatic t_edge_clear();
    logic [31:0] d;
    @(negedge clk); irq_lines[5] = 1'b1; irq_lines[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd('h00, d); chk("R1 edge sets line 5, not 0", d, 32'h0000_0020);
    chk("R4 masked line gives no request", {24'h0, cpu_req}, 32'h0);
    wr('h01, 32'h0000_0020);
    repeat (2) @(negedge clk);
    rd('h00, d); chk("R9 clear while line high, no re-set (R1)", d, 32'h0);
    rd('h01, d); chk("R9 clear register reads 0", d, 32'h0);
    irq_lines = '0;
    wr('h10, 32'hFFFF_FFFF);
    rd('h10, d); chk("R4 mask bit 0 reads 0", d, 32'hFFFF_FFFE);
    cleanup();
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr('h10, 32'h0000_FFFE);
    wr('h11, 32'h0000_0008);
    pulse(32'h0000_0208);
    chk("R5 cpu0 highest level 9, cpu1 level 3", {24'h0, cpu_req}, 32'h0000_0039);
    ack(0, 4'd9);
    rd('h00, d); chk("R7 ack of 9 clears only 9", d, 32'h0000_0008);
    chk("R5 cpu0 falls to level 3", {24'h0, cpu_req}, 32'h0000_0033);
    ack(0, 4'd0);
    rd('h00, d); chk("R7 ack of level 0 has no effect", d, 32'h0000_0008);
    ack(1, 4'd3);
    chk("R7 both requests idle", {24'h0, cpu_req}, 32'h0);
    cleanup();
  endtask

  task automatic t_extension();
    logic [31:0] d;
    wr('h10, 32'h0210_1000);
    wr('h11, 32'h0000_1000);
    pulse(32'h0214_0000);
    chk("R6 ext lines raise level 12 for cpu0 only", {24'h0, cpu_req}, 32'h0000_000C);
    ack(0, 4'd12);
    rd('h00, d); chk("R8 lowest enabled ext (20) cleared", d, 32'h0204_0000);
    rd('h18, d); chk("R8 id0 records offset 4", d, 32'h0000_0014);
    chk("R6 level 12 still requested", {24'h0, cpu_req}, 32'h0000_000C);
    ack(0, 4'd12);
    rd('h18, d); chk("R8 id0 records offset 9", d, 32'h0000_0019);
    chk("R6 masked ext line 18 gives no request", {24'h0, cpu_req}, 32'h0);
    ack(0, 4'd12);
    rd('h18, d); chk("R8 id0 zero when no ext line", d, 32'h0);
    rd('h00, d); chk("R8 masked line 18 left pending", d, 32'h0004_0000);
    p_sel = 1'b1; p_addr = AW'('h00);
    #1 chk("R2 no ext pending without extension", p_rdata & 32'hFFFF_0000, 32'h0);
    p_sel = 1'b0;
    cleanup();
  endtask

  task automatic t_csel_ro();
    logic [31:0] d;
    wr('h03, 32'h3A00_0000);
    chk("R11 cpu0 top nibble, cpu1 next", {24'h0, cpu_csel}, 32'h0000_00A3);
    rd('h03, d); chk("R11 csel readback", d, 32'h3A00_0000);
    wr('h00, 32'hFFFF_FFFF);
    rd('h00, d); chk("R12 pending write ignored", d, 32'h0);
    wr('h18, 32'h0000_001F);
    rd('h18, d); chk("R12 id write ignored", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr('h10, 32'h0000_0080);
    pulse(32'h0000_00C0);
    @(negedge clk);
    cpu_ack[0] = 1'b1; cpu_ack_lvl[3:0] = 4'd7;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'('h01); bus_wdata = 32'h0000_0040;
    irq_lines[7] = 1'b1; irq_lines[6] = 1'b1;
    @(negedge clk);
    cpu_ack = '0; cpu_ack_lvl = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    irq_lines = '0;
    rd('h00, d); chk("R10 edge beats ack and clear", d, 32'h0000_00C0);
    chk("R10 request stays at 7", {24'h0, cpu_req}, 32'h0000_0007);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_edge_clear();
    t_priority();
    t_extension();
    t_csel_ro();
    t_race();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule